// File: doc/BRIEF.md
# Pixel Depth Reducer with LFSR Spatial Dither

The block takes one RGB pixel per valid cycle at `IN_W` bits per channel and reduces each channel to a 6-bit or 8-bit result. It can simply drop the low bits, or it can first add a pseudo-random value and then drop them. The random values come from one 28-bit linear feedback shift register per channel, and each register has its own seed. The reduced result keeps the input width. Its dropped low bits are forced to zero, so the stage that follows takes the top 6 or 8 bits.

A single 8-bit control word holds all the settings: truncation enable and depth, dither enable and depth, per-channel polynomial selection, and per-frame reseeding. In per-frame mode, a 4-bit frame counter is mixed into the seeds at each frame start, so that successive frames get different patterns. Without that mode, the registers are seeded once when dither is switched on.

Top module: `pix_depth_reducer`

## Requirements
- R1: `valid_o` is `valid_i` delayed by one clock. `pix_o` updates one clock after a valid input and holds its value otherwise. Reset drives both to zero.
- R2: `ctrl_i` bit fields are: bit 0 truncation enable, bits 2:1 truncation depth, bit 3 dither enable, bits 5:4 dither depth, bit 6 per-channel polynomial mode, bit 7 per-frame reseed. Depth code 0 selects 6-bit output and code 1 selects 8-bit output. Code 2 or 3 disables that function.
- R3: With only truncation active, each channel keeps its top 6 or 8 bits and its remaining low bits read as zero.
- R4: While dither is inactive, each channel's register loads continuously from its seed (red from `seed_r_i`, green from `seed_g_i`, blue from `seed_b_i`). The first pixel after dither turns on therefore uses the seed.
- R5: With dither active, each register advances once per valid pixel: next = {s[26:0], s[27]^s[T-1]}, with T=3 for all channels when per-channel mode is off (x^28+x^3+1).
- R6: With per-channel mode on, T is 3 for red, 9 for green and 13 for blue.
- R7: With dither active, the low dropped-width bits of the channel's register are added to the input. The sum saturates at 2^IN_W-1 before the low bits are cleared.
- R8: With both functions inactive, `pix_o` equals the input pixel.
- R9: When both functions are active, the dither depth sets the output width.
- R10: With per-frame reseed and dither active, `frame_start_i` loads each register with seed XOR (bit-reversed 4-bit frame count << 24). The count then steps 0..15 and wraps. Otherwise `frame_start_i` has no effect and the count stays 0.
- R11: When a valid pixel arrives in the same cycle as a reseed, the pixel uses the register state from before the reload, and the register does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Control word (see R2) |
| seed_r_i | input | 28 | Red register seed |
| seed_g_i | input | 28 | Green register seed |
| seed_b_i | input | 28 | Blue register seed |
| frame_start_i | input | 1 | Frame start strobe |
| valid_i | input | 1 | Input pixel valid |
| pix_i | input | 3*IN_W | Pixel {red, green, blue}, red in the top bits |
| valid_o | output | 1 | Output pixel valid |
| pix_o | output | 3*IN_W | Reduced pixel, same packing, dropped bits zero |

## Verification
A register that steps at the wrong time, or uses the wrong tap, shows up at the ports on the first dithered pixel whose random low bits differ from the expected ones. That is usually within one or two valid pixels, because the bench tracks each channel's register state independently. A frame counter fault appears on the second frame start in per-frame mode, when the reseed value no longer matches the seed alone. A saturation fault appears only when near-full-scale inputs meet nonzero random bits, so directed all-ones pixels with seeds that have set low bits are included.

// File: rtl/pix_dith_pkg.sv
package pix_dith_pkg;
  localparam int LFSR_W      = 28;
  localparam int TAP_SHARED  = 3;
  localparam int TAP_GREEN   = 9;
  localparam int TAP_BLUE    = 13;
  localparam int FRM_CNT_W   = 4;
  localparam int FRM_CNT_MAX = 15;
  localparam int NUM_CH      = 3;

  typedef struct packed {
    logic       frm_rand;
    logic       rgb_rand;
    logic [1:0] dith_depth;
    logic       dith_en;
    logic [1:0] trunc_depth;
    logic       trunc_en;
  } ctrl_t;

  typedef struct packed {
    logic trunc_act;
    logic dith_act;
    logic wide;
  } mode_t;

  function automatic logic [FRM_CNT_W-1:0] bit_rev(input logic [FRM_CNT_W-1:0] v);
    logic [FRM_CNT_W-1:0] r;
    for (int i = 0; i < FRM_CNT_W; i++) r[i] = v[FRM_CNT_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/pix_ctrl_decode.sv
module pix_ctrl_decode
  import pix_dith_pkg::*;
(
  input  ctrl_t ctrl_i,
  output mode_t mode_o
);
  logic dith_ok, trunc_ok;

  // depth codes 2 and 3 are rejected: the function stays off
  assign dith_ok  = ctrl_i.dith_en  && !ctrl_i.dith_depth[1];
  assign trunc_ok = ctrl_i.trunc_en && !ctrl_i.trunc_depth[1];

  always_comb begin
    mode_o.dith_act  = dith_ok;
    mode_o.trunc_act = trunc_ok;
    mode_o.wide      = dith_ok ? ctrl_i.dith_depth[0] : ctrl_i.trunc_depth[0];
  end
endmodule

// File: rtl/pix_lfsr.sv
module pix_lfsr #(
  parameter int W     = 28,
  parameter int TAP_A = 3,
  parameter int TAP_B = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         alt_i,
  output logic [W-1:0] state_o
);
  logic fb;

  assign fb = state_o[W-1] ^ (alt_i ? state_o[TAP_B-1] : state_o[TAP_A-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= '0;
    else if (load_i) state_o <= load_val_i;
    else if (step_i) state_o <= {state_o[W-2:0], fb};
  end

  a_r4_seed_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_o == $past(load_val_i));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(state_o));

  a_r5_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> state_o[W-1:1] == $past(state_o[W-2:0]));
endmodule

// File: rtl/pix_frame_seq.sv
module pix_frame_seq
  import pix_dith_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_i,
  input  logic                 frame_start_i,
  output logic                 reseed_o,
  output logic [FRM_CNT_W-1:0] cnt_o
);
  localparam logic [FRM_CNT_W-1:0] CNT_MAX = FRM_CNT_W'(FRM_CNT_MAX);

  assign reseed_o = act_i && frame_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (!act_i)   cnt_o <= '0;
    else if (reseed_o) cnt_o <= (cnt_o == CNT_MAX) ? '0 : cnt_o + 1'b1;
  end

  a_r10_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> cnt_o == '0);

  a_r10_cnt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reseed_o && cnt_o == CNT_MAX) |=> cnt_o == '0);
endmodule

// File: rtl/pix_chan_reduce.sv
module pix_chan_reduce
  import pix_dith_pkg::*;
#(
  parameter int IN_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  mode_t           mode_i,
  input  logic [IN_W-1:0] x_i,
  input  logic [IN_W-1:0] rnd_i,
  output logic [IN_W-1:0] y_o
);
  localparam int DROP_N = IN_W - 6;
  localparam int DROP_W = IN_W - 8;
  localparam logic [IN_W-1:0] MASK_N = {{(IN_W-DROP_N){1'b0}}, {DROP_N{1'b1}}};
  localparam logic [IN_W-1:0] MASK_W = {{(IN_W-DROP_W){1'b0}}, {DROP_W{1'b1}}};

  logic [IN_W-1:0] mask, addend, sat;
  logic [IN_W:0]   sum;

  always_comb begin
    if (mode_i.dith_act || mode_i.trunc_act) mask = mode_i.wide ? MASK_W : MASK_N;
    else                                     mask = '0;
    addend = mode_i.dith_act ? (rnd_i & mask) : '0;
    sum    = {1'b0, x_i} + {1'b0, addend};
    sat    = sum[IN_W] ? '1 : sum[IN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      y_o <= '0;
    else if (valid_i) y_o <= sat & ~mask;
  end

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i.dith_act) |=> y_o >= ($past(x_i) & ~$past(mask)));

  a_r3_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i.trunc_act && !mode_i.dith_act) |=> (y_o & $past(mask)) == '0);
endmodule

// File: rtl/pix_depth_reducer.sv
module pix_depth_reducer
  import pix_dith_pkg::*;
#(
  parameter int IN_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           ctrl_i,
  input  logic [LFSR_W-1:0]    seed_r_i,
  input  logic [LFSR_W-1:0]    seed_g_i,
  input  logic [LFSR_W-1:0]    seed_b_i,
  input  logic                 frame_start_i,
  input  logic                 valid_i,
  input  logic [3*IN_W-1:0]    pix_i,
  output logic                 valid_o,
  output logic [3*IN_W-1:0]    pix_o
);
  localparam int CNT_SHIFT = LFSR_W - FRM_CNT_W;

  ctrl_t                ctrl;
  mode_t                mode;
  logic                 reseed;
  logic [FRM_CNT_W-1:0] frm_cnt;
  logic [LFSR_W-1:0]    seed_a [NUM_CH];
  logic [LFSR_W-1:0]    mix;

  assign ctrl      = ctrl_t'(ctrl_i);
  assign seed_a[0] = seed_r_i;
  assign seed_a[1] = seed_g_i;
  assign seed_a[2] = seed_b_i;
  assign mix       = reseed ? {bit_rev(frm_cnt), {CNT_SHIFT{1'b0}}} : '0;

  pix_ctrl_decode u_dec (.ctrl_i(ctrl), .mode_o(mode));

  pix_frame_seq u_frm (
    .clk_i, .rst_ni,
    .act_i        (mode.dith_act && ctrl.frm_rand),
    .frame_start_i,
    .reseed_o     (reseed),
    .cnt_o        (frm_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int ALT_TAP = (c == 0) ? TAP_SHARED : (c == 1) ? TAP_GREEN : TAP_BLUE;
    logic [LFSR_W-1:0] st;
    logic [IN_W-1:0]   y;

    pix_lfsr #(.W(LFSR_W), .TAP_A(TAP_SHARED), .TAP_B(ALT_TAP)) u_lfsr (
      .clk_i, .rst_ni,
      .load_i     (!mode.dith_act || reseed),
      .load_val_i (seed_a[c] ^ mix),
      .step_i     (mode.dith_act && valid_i),
      .alt_i      (ctrl.rgb_rand),
      .state_o    (st)
    );

    pix_chan_reduce #(.IN_W(IN_W)) u_red (
      .clk_i, .rst_ni,
      .valid_i,
      .mode_i (mode),
      .x_i    (pix_i[(NUM_CH-c)*IN_W-1 -: IN_W]),
      .rnd_i  (st[IN_W-1:0]),
      .y_o    (y)
    );

    assign pix_o[(NUM_CH-c)*IN_W-1 -: IN_W] = y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  a_r1_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(pix_o)));

  a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode.dith_act && !mode.trunc_act) |=> pix_o == $past(pix_i));
endmodule

// File: tb/pix_depth_reducer_tb_top.sv
module pix_depth_reducer_tb_top;
  localparam int CLK_NS = 10;
  localparam int IN_W   = 10;
  localparam int PW     = 3 * IN_W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    ctrl_i = '0;
  logic [27:0]   seed_r_i = '0, seed_g_i = '0, seed_b_i = '0;
  logic          frame_start_i = 1'b0;
  logic          valid_i = 1'b0;
  logic [PW-1:0] pix_i = '0;
  logic          valid_o;
  logic [PW-1:0] pix_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [27:0]   m_st [3];
  int            m_cnt = 0;
  logic [PW-1:0] last_p = '0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  pix_depth_reducer #(.IN_W(IN_W)) dut_i (.*);

  function automatic logic [27:0] seed_of(input int c);
    return (c == 0) ? seed_r_i : (c == 1) ? seed_g_i : seed_b_i;
  endfunction

  function automatic int tap_of(input int c, input logic rgb);
    if (!rgb) return 3;
    return (c == 0) ? 3 : (c == 1) ? 9 : 13;
  endfunction

  function automatic logic [IN_W-1:0] ref_chan(input logic [IN_W-1:0] x,
                                               input logic [27:0] st,
                                               input logic [7:0] c);
    bit dact, tact;
    int keep, drop;
    int s;
    int mask;
    dact = c[3] && !c[5];
    tact = c[0] && !c[2];
    if (dact)      keep = c[4] ? 8 : 6;
    else if (tact) keep = c[1] ? 8 : 6;
    else           keep = IN_W;
    drop = IN_W - keep;
    mask = (1 << drop) - 1;
    s = int'(x);
    if (dact) s = s + (int'(st[IN_W-1:0]) & mask);
    if (s > (1 << IN_W) - 1) s = (1 << IN_W) - 1;
    s = s & ~mask;
    return IN_W'(s);
  endfunction

  task automatic set_seeds(input logic [27:0] r, input logic [27:0] g, input logic [27:0] b);
    seed_r_i = r; seed_g_i = g; seed_b_i = b;
  endtask

  task automatic cyc(input logic [7:0] c, input logic fs, input logic v,
                     input logic [PW-1:0] p, input string tag);
    logic [PW-1:0] exp_p;
    bit dact, fr;
    ctrl_i = c; frame_start_i = fs; valid_i = v; pix_i = p;
    exp_p = last_p;
    if (v) for (int k = 0; k < 3; k++)
      exp_p[(3-k)*IN_W-1 -: IN_W] = ref_chan(p[(3-k)*IN_W-1 -: IN_W], m_st[k], c);
    dact = c[3] && !c[5];
    fr   = c[7];
    if (!dact) begin
      for (int k = 0; k < 3; k++) m_st[k] = seed_of(k);
      m_cnt = 0;
    end else if (fr && fs) begin
      logic [3:0] cv, rv;
      cv = 4'(m_cnt);
      rv = {cv[0], cv[1], cv[2], cv[3]};
      for (int k = 0; k < 3; k++) m_st[k] = seed_of(k) ^ {rv, 24'h0};
      m_cnt = (m_cnt == 15) ? 0 : m_cnt + 1;
    end else begin
      if (!fr) m_cnt = 0;
      if (v) for (int k = 0; k < 3; k++)
        m_st[k] = {m_st[k][26:0], m_st[k][27] ^ m_st[k][tap_of(k, c[6]) - 1]};
    end
    last_p = exp_p;
    @(negedge clk_i);
    checks++;
    if (valid_o !== v || pix_o !== exp_p) begin
      errors++;
      $display("FAIL %s: valid=%0b pix=%h expected valid=%0b pix=%h", tag, valid_o, pix_o, v, exp_p);
    end
  endtask

  function automatic logic [PW-1:0] rnd_pix();
    return PW'({$urandom, $urandom});
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) m_st[k] = '0;
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || pix_o !== '0) begin
      errors++;
      $display("FAIL R1 reset: valid=%0b pix=%h expected 0 0", valid_o, pix_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8 pass-through
    for (int i = 0; i < 6; i++) cyc(8'h00, 1'b0, 1'b1, rnd_pix(), "R8");
    cyc(8'h00, 1'b0, 1'b0, rnd_pix(), "R1");
    // R3 truncation, both depths
    cyc(8'h01, 1'b0, 1'b1, {3{10'h3FF}}, "R3");
    cyc(8'h03, 1'b0, 1'b1, {3{10'h3FF}}, "R3");
    for (int i = 0; i < 6; i++) cyc(8'h01 | (8'(i & 1) << 1), 1'b0, 1'b1, rnd_pix(), "R3");
    // R2 rejected depth codes
    cyc(8'h05, 1'b0, 1'b1, rnd_pix(), "R2");
    cyc(8'h07, 1'b0, 1'b1, rnd_pix(), "R2");
    cyc(8'h28, 1'b0, 1'b1, rnd_pix(), "R2");
    cyc(8'h38, 1'b0, 1'b1, rnd_pix(), "R2");
    // R4 seeds, R5 shared polynomial
    set_seeds(28'hA5C3E1F, 28'h1234567, 28'h0F0F0F3);
    cyc(8'h00, 1'b0, 1'b0, '0, "R4");
    cyc(8'h08, 1'b0, 1'b1, {10'h100, 10'h200, 10'h080}, "R4");
    for (int i = 0; i < 20; i++) cyc(8'h08, 1'b0, (i % 3) != 0, rnd_pix(), "R5");
    // R7 saturation
    set_seeds(28'hFFFFFFF, 28'h000000F, 28'h0000003);
    cyc(8'h00, 1'b0, 1'b0, '0, "R7");
    cyc(8'h08, 1'b0, 1'b1, {3{10'h3FF}}, "R7");
    cyc(8'h18, 1'b0, 1'b1, {3{10'h3FE}}, "R7");
    // R6 per-channel polynomials
    set_seeds(28'h8000001, 28'h4000100, 28'h2001000);
    cyc(8'h00, 1'b0, 1'b0, '0, "R6");
    for (int i = 0; i < 40; i++) cyc(8'h48, 1'b0, 1'b1, rnd_pix(), "R6");
    // R9 both active: dither depth wins
    cyc(8'h00, 1'b0, 1'b0, '0, "R9");
    for (int i = 0; i < 8; i++) cyc(8'h0B, 1'b0, 1'b1, rnd_pix(), "R9");
    for (int i = 0; i < 8; i++) cyc(8'h19, 1'b0, 1'b1, rnd_pix(), "R9");
    // R10 per-frame reseed and counter wrap
    cyc(8'h00, 1'b0, 1'b0, '0, "R10");
    for (int f = 0; f < 20; f++) begin
      cyc(8'h88, 1'b1, 1'b0, '0, "R10");
      for (int i = 0; i < 3; i++) cyc(8'h88, 1'b0, 1'b1, rnd_pix(), "R10");
    end
    // R10 frame start ignored without per-frame mode
    for (int i = 0; i < 6; i++) cyc(8'h08, i[0], 1'b1, rnd_pix(), "R10");
    // R11 reseed collides with a valid pixel
    for (int f = 0; f < 5; f++) begin
      cyc(8'hC8, 1'b1, 1'b1, rnd_pix(), "R11");
      cyc(8'hC8, 1'b0, 1'b1, rnd_pix(), "R11");
    end

    // constrained random
    begin
      logic [7:0] c;
      c = '0;
      for (int i = 0; i < 4000; i++) begin
        if (i % 60 == 0) begin
          c = 8'($urandom);
          if ($urandom_range(3) == 0) set_seeds(28'($urandom), 28'($urandom), 28'($urandom));
        end
        cyc(c, $urandom_range(15) == 0, $urandom_range(3) != 0,
            ($urandom_range(9) == 0) ? {3{10'h3FF}} : rnd_pix(),
            c[3] ? "R7" : (c[0] ? "R3" : "R8"));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule